// File: doc/BRIEF.md
# Compelled Signaling Sequence Controller

This block decides, for one signaling channel, which multifrequency tone code the transmitter should send. It takes transmit requests from the host as decoded 4-bit tone codes. It also takes tone-present and tone-absent events from a tone detector, each carrying the received code. From these it drives the active transmit code and a report strobe with the received code back to the host. Tone synthesis, tone detection and the host bus sit outside the block.

In manual mode the host alone turns the transmitter on and off. In automatic compelled mode the block runs the interlocked handshake itself. It keeps a two-state view of the far end: "quiet" when no far-end tone is detected and "far" when one is. Whether sending is permitted depends on that state and on the channel role. In the forward role sending is permitted only while quiet. In the backward role it is permitted only while the far tone is present. A request that arrives while sending is not permitted is held in a one-entry slot, and it is released when the state changes to permit sending. When the state changes so that sending is no longer permitted, the transmitter is silenced.

Top module: `mcc_ctrl`

## Requirements
- R1: After reset, `tx_code_o` is 0000 (tone off), `far_sig_o` is 0 (quiet) and `rpt_valid_o` is 0.
- R2: While enabled, a tone-present event sets `far_sig_o` to 1 on the next cycle, and a tone-absent event clears it. If both events arrive in the same cycle, tone-present wins.
- R3: In automatic mode with the forward role (`fwd_role_i`=1), a request made while quiet sets `tx_code_o` to the requested code on the next cycle.
- R4: In automatic mode with the forward role, a tone-present event sets `tx_code_o` to 0000 on the next cycle. A request made while the far tone is present leaves `tx_code_o` at 0000.
- R5: In automatic mode with the forward role, a request held while the far tone was present appears on `tx_code_o` in the cycle after the tone-absent event.
- R6: In automatic mode with the backward role (`fwd_role_i`=0), the rules are mirrored. A request made while quiet is held and `tx_code_o` stays 0000. A tone-present event releases the held request on the next cycle. A request made while the far tone is present acts on the next cycle. A tone-absent event sets `tx_code_o` to 0000.
- R7: Only one request is held. A newer held request replaces the older one. The held request is discarded whenever sending becomes permitted, and in manual mode.
- R8: In manual mode (`auto_i`=0), every request sets `tx_code_o` on the next cycle in either state, and detector events never change `tx_code_o`.
- R9: While enabled, a tone-present event raises `rpt_valid_o` for exactly one cycle on the next cycle, with `rpt_code_o` equal to the detected code.
- R10: A tone-absent event produces a one-cycle report with code 0000 when `eod_en_i` is 1, and no report when `eod_en_i` is 0.
- R11: While `chan_en_i` is 0, detector events and requests have no effect. `far_sig_o` and `tx_code_o` hold their values, so a sending transmitter keeps sending, and no report is made.
- R12: A request is judged against the state after same-cycle detector events. With the forward role, a request arriving together with a tone-present event is held. A request arriving together with the tone-absent event that permits sending is sent in preference to the older held request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable |
| auto_i | input | 1 | 1 = automatic compelled mode, 0 = manual |
| fwd_role_i | input | 1 | 1 = forward role, 0 = backward role |
| eod_en_i | input | 1 | Report tone-absent events with code 0000 |
| cmd_valid_i | input | 1 | Transmit request strobe |
| cmd_code_i | input | CODE_W | Requested tone code, 0000 = tone off |
| det_on_i | input | 1 | Detector tone-present event |
| det_off_i | input | 1 | Detector tone-absent event |
| det_code_i | input | CODE_W | Code carried by the tone-present event |
| tx_code_o | output | CODE_W | Active transmit code, 0000 = off |
| far_sig_o | output | 1 | Handshake state, 1 = far tone present |
| rpt_valid_o | output | 1 | One-cycle report strobe |
| rpt_code_o | output | CODE_W | Reported code |

## Verification
The assertions assume that detector events are single-cycle pulses. They also assume that the tone-present and tone-absent pulses are not raised together, except where the rule that tone-present wins is exercised. The random stimulus keeps the two events mutually exclusive by drawing one event kind per cycle. It changes the mode and role bits only at long intervals, so that full handshakes run under each setting. Directed sequences cover same-cycle request and event ordering, the disabled channel and the end-of-digit option.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic {
    HS_QUIET = 1'b0,
    HS_FAR   = 1'b1
  } hs_state_e;

  // sending permitted: forward role while quiet, backward role while far tone present
  function automatic logic send_ok(input logic fwd, input hs_state_e st);
    return fwd ? (st == HS_QUIET) : (st == HS_FAR);
  endfunction
endpackage

// File: rtl/mcc_state.sv
module mcc_state
  import mcc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      on_i,
  input  logic      off_i,
  output hs_state_e st_d_o,
  output hs_state_e st_q_o
);
  hs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (en_i) begin
      if (on_i)       st_d = HS_FAR;
      else if (off_i) st_d = HS_QUIET;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= HS_QUIET;
    else         st_q <= st_d;
  end

  assign st_d_o = st_d;
  assign st_q_o = st_q;
endmodule

// File: rtl/mcc_pend.sv
module mcc_pend #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              vld_o,
  output logic [CODE_W-1:0] code_o
);
  logic              vld_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      code_q <= '0;
    end else if (load_i) begin
      vld_q  <= 1'b1;     // newest request overwrites
      code_q <= code_i;
    end else if (clr_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign vld_o  = vld_q;
  assign code_o = code_q;
endmodule

// File: rtl/mcc_report.sv
module mcc_report #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              eod_en_i,
  input  logic              on_i,
  input  logic              off_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              vld_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] EodCode = '0;

  logic              vld_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      code_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (en_i) begin
        if (on_i) begin
          vld_q  <= 1'b1;
          code_q <= code_i;
        end else if (off_i && eod_en_i) begin
          vld_q  <= 1'b1;
          code_q <= EodCode;
        end
      end
    end
  end

  assign vld_o  = vld_q;
  assign code_o = code_q;
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
#(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_en_i,
  input  logic              auto_i,
  input  logic              fwd_role_i,
  input  logic              eod_en_i,
  input  logic              cmd_valid_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic              det_on_i,
  input  logic              det_off_i,
  input  logic [CODE_W-1:0] det_code_i,
  output logic [CODE_W-1:0] tx_code_o,
  output logic              far_sig_o,
  output logic              rpt_valid_o,
  output logic [CODE_W-1:0] rpt_code_o
);
  localparam logic [CODE_W-1:0] ToneOff = '0;

  hs_state_e         st_q, st_d;
  logic              ok_now, ok_next, enter_ok;
  logic              pend_load, pend_clr, pend_vld;
  logic [CODE_W-1:0] pend_code;
  logic [CODE_W-1:0] tx_q, tx_d;

  mcc_state u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (chan_en_i),
    .on_i   (det_on_i),
    .off_i  (det_off_i),
    .st_d_o (st_d),
    .st_q_o (st_q)
  );

  // requests are judged against the post-event state
  assign ok_now   = send_ok(fwd_role_i, st_q);
  assign ok_next  = send_ok(fwd_role_i, st_d);
  assign enter_ok = ok_next & ~ok_now;

  assign pend_load = chan_en_i & auto_i & ~ok_next & cmd_valid_i;
  assign pend_clr  = chan_en_i & (~auto_i | ok_next);

  mcc_pend #(.CODE_W(CODE_W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pend_load),
    .clr_i  (pend_clr),
    .code_i (cmd_code_i),
    .vld_o  (pend_vld),
    .code_o (pend_code)
  );

  always_comb begin
    tx_d = tx_q;
    if (chan_en_i) begin
      if (!auto_i) begin
        if (cmd_valid_i) tx_d = cmd_code_i;
      end else if (ok_next) begin
        if (cmd_valid_i)               tx_d = cmd_code_i;
        else if (enter_ok && pend_vld) tx_d = pend_code;
      end else begin
        tx_d = ToneOff;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= ToneOff;
    else         tx_q <= tx_d;
  end

  mcc_report #(.CODE_W(CODE_W)) u_rpt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (chan_en_i),
    .eod_en_i (eod_en_i),
    .on_i     (det_on_i),
    .off_i    (det_off_i),
    .code_i   (det_code_i),
    .vld_o    (rpt_valid_o),
    .code_o   (rpt_code_o)
  );

  assign tx_code_o = tx_q;
  assign far_sig_o = (st_q == HS_FAR);
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chan_en_i,
  input logic              auto_i,
  input logic              fwd_role_i,
  input logic              eod_en_i,
  input logic              cmd_valid_i,
  input logic [CODE_W-1:0] cmd_code_i,
  input logic              det_on_i,
  input logic              det_off_i,
  input logic [CODE_W-1:0] det_code_i,
  input logic [CODE_W-1:0] tx_code_o,
  input logic              far_sig_o,
  input logic              rpt_valid_o,
  input logic [CODE_W-1:0] rpt_code_o
);
  p_far_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && det_on_i |=> far_sig_o);

  p_far_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && det_off_i && !det_on_i |=> !far_sig_o);

  p_fwd_silence_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && auto_i && fwd_role_i && det_on_i |=> tx_code_o == '0);

  p_bwd_silence_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && auto_i && !fwd_role_i && det_off_i && !det_on_i |=> tx_code_o == '0);

  p_manual_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && !auto_i && cmd_valid_i |=> tx_code_o == $past(cmd_code_i));

  p_manual_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && !auto_i && !cmd_valid_i |=> $stable(tx_code_o));

  p_report_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && det_on_i |=> rpt_valid_o && rpt_code_o == $past(det_code_i));

  p_eod_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && det_off_i && !det_on_i && eod_en_i |=> rpt_valid_o && rpt_code_o == '0);

  p_eod_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && det_off_i && !det_on_i && !eod_en_i |=> !rpt_valid_o);

  p_disabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> $stable(tx_code_o) && $stable(far_sig_o) && !rpt_valid_o);
endmodule

bind mcc_ctrl mcc_checker #(.CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_en_i   (chan_en_i),
  .auto_i      (auto_i),
  .fwd_role_i  (fwd_role_i),
  .eod_en_i    (eod_en_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_code_i  (cmd_code_i),
  .det_on_i    (det_on_i),
  .det_off_i   (det_off_i),
  .det_code_i  (det_code_i),
  .tx_code_o   (tx_code_o),
  .far_sig_o   (far_sig_o),
  .rpt_valid_o (rpt_valid_o),
  .rpt_code_o  (rpt_code_o)
);

// File: tb/mcc_ctrl_bench.sv
module mcc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          chan_en_i = 1'b0, auto_i = 1'b0, fwd_role_i = 1'b0, eod_en_i = 1'b0;
  logic          cmd_valid_i = 1'b0, det_on_i = 1'b0, det_off_i = 1'b0;
  logic [CW-1:0] cmd_code_i = '0, det_code_i = '0;
  logic [CW-1:0] tx_code_o, rpt_code_o;
  logic          far_sig_o, rpt_valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  bit          m_far, m_pv, m_rv;
  logic [CW-1:0] m_tx, m_pc, m_rc;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcc_ctrl #(.CODE_W(CW)) u_mcc_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .chan_en_i(chan_en_i), .auto_i(auto_i),
    .fwd_role_i(fwd_role_i), .eod_en_i(eod_en_i), .cmd_valid_i(cmd_valid_i),
    .cmd_code_i(cmd_code_i), .det_on_i(det_on_i), .det_off_i(det_off_i),
    .det_code_i(det_code_i), .tx_code_o(tx_code_o), .far_sig_o(far_sig_o),
    .rpt_valid_o(rpt_valid_o), .rpt_code_o(rpt_code_o)
  );

  function automatic bit allowed(input bit fwd, input bit far);
    return fwd ? !far : far;
  endfunction

  task automatic model_step();
    bit far_n, ok_c, ok_n;
    m_rv = 1'b0;
    if (chan_en_i) begin
      far_n = det_on_i ? 1'b1 : (det_off_i ? 1'b0 : m_far);
      if (det_on_i) begin m_rv = 1'b1; m_rc = det_code_i; end
      else if (det_off_i && eod_en_i) begin m_rv = 1'b1; m_rc = '0; end
      if (!auto_i) begin
        if (cmd_valid_i) m_tx = cmd_code_i;
        m_pv = 1'b0;
      end else begin
        ok_c = allowed(fwd_role_i, m_far);
        ok_n = allowed(fwd_role_i, far_n);
        if (ok_n) begin
          if (cmd_valid_i) m_tx = cmd_code_i;
          else if (!ok_c && m_pv) m_tx = m_pc;
          m_pv = 1'b0;
        end else begin
          m_tx = '0;
          if (cmd_valid_i) begin m_pv = 1'b1; m_pc = cmd_code_i; end
        end
      end
      m_far = far_n;
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit au, input bit fw, input bit eo,
                      input bit cv, input logic [CW-1:0] cc,
                      input bit on, input bit off, input logic [CW-1:0] dc,
                      input string tag);
    chan_en_i = en; auto_i = au; fwd_role_i = fw; eod_en_i = eo;
    cmd_valid_i = cv; cmd_code_i = cc; det_on_i = on; det_off_i = off; det_code_i = dc;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "tx_code", int'(tx_code_o), int'(m_tx));
    chk(tag, "far_sig", int'(far_sig_o), int'(m_far));
    chk(tag, "rpt_valid", int'(rpt_valid_o), int'(m_rv));
    if (m_rv) chk(tag, "rpt_code", int'(rpt_code_o), int'(m_rc));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_far = 0; m_pv = 0; m_rv = 0; m_tx = '0; m_pc = '0; m_rc = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "tx_code", int'(tx_code_o), 0);
    chk("R1", "far_sig", int'(far_sig_o), 0);
    chk("R1", "rpt_valid", int'(rpt_valid_o), 0);

    // forward automatic handshake
    step(1,1,1,1, 1,4'd5, 0,0,4'd0, "R3");
    chk("R3", "tx direct", int'(tx_code_o), 5);
    step(1,1,1,1, 0,4'd0, 1,0,4'd3, "R4 R9 R2");
    chk("R4", "tx forced off", int'(tx_code_o), 0);
    chk("R9", "rpt code", int'(rpt_code_o), 3);
    step(1,1,1,1, 0,4'd0, 0,0,4'd0, "R9");
    chk("R9", "one-cycle strobe", int'(rpt_valid_o), 0);
    step(1,1,1,1, 1,4'd7, 0,0,4'd0, "R4");
    chk("R4", "tx held off", int'(tx_code_o), 0);
    step(1,1,1,1, 1,4'd9, 0,0,4'd0, "R7");
    step(1,1,1,1, 0,4'd0, 0,1,4'd0, "R5 R10");
    chk("R7", "newest pending", int'(tx_code_o), 9);
    chk("R10", "eod code", int'(rpt_code_o), 0);

    // same-cycle ordering, forward
    step(1,1,1,0, 1,4'd6, 1,0,4'd2, "R12");
    chk("R12", "cmd with entry held", int'(tx_code_o), 0);
    step(1,1,1,0, 1,4'd11, 0,1,4'd0, "R12 R10");
    chk("R12", "new cmd beats pending", int'(tx_code_o), 11);
    chk("R10", "no eod report", int'(rpt_valid_o), 0);

    // backward automatic handshake
    step(1,1,0,1, 0,4'd0, 0,0,4'd0, "R6");
    chk("R6", "quiet backward off", int'(tx_code_o), 0);
    step(1,1,0,1, 1,4'd12, 0,0,4'd0, "R6");
    chk("R6", "held in quiet", int'(tx_code_o), 0);
    step(1,1,0,1, 0,4'd0, 1,0,4'd1, "R6");
    chk("R6", "released on far", int'(tx_code_o), 12);
    step(1,1,0,1, 1,4'd4, 0,0,4'd0, "R6");
    chk("R6", "direct on far", int'(tx_code_o), 4);
    step(1,1,0,1, 0,4'd0, 0,1,4'd0, "R6");
    chk("R6", "off on quiet", int'(tx_code_o), 0);

    // manual mode
    step(1,0,1,1, 1,4'd8, 0,0,4'd0, "R8");
    chk("R8", "manual send", int'(tx_code_o), 8);
    step(1,0,1,1, 0,4'd0, 1,0,4'd10, "R8 R2");
    chk("R8", "detector no gate", int'(tx_code_o), 8);
    step(1,0,1,1, 1,4'd13, 0,0,4'd0, "R8");
    chk("R8", "manual send far", int'(tx_code_o), 13);
    step(1,0,1,1, 0,4'd0, 1,1,4'd14, "R2");
    chk("R2", "present wins", int'(far_sig_o), 1);

    // disabled channel
    step(0,1,1,1, 0,4'd0, 0,1,4'd0, "R11");
    chk("R11", "state held", int'(far_sig_o), 1);
    chk("R11", "no report", int'(rpt_valid_o), 0);
    chk("R11", "tx keeps sending", int'(tx_code_o), 13);
    step(0,0,1,1, 1,4'd2, 1,0,4'd5, "R11");
    chk("R11", "cmd ignored", int'(tx_code_o), 13);

    // constrained random
    begin
      bit au = 1, fw = 1, eo = 1;
      for (int i = 0; i < 6000; i++) begin
        int ev;
        bit en, cv;
        if (i % 150 == 0) begin
          au = ($urandom % 4) != 0;
          fw = $urandom % 2;
          eo = $urandom % 2;
        end
        en = ($urandom % 12) != 0;
        cv = ($urandom % 5) == 0;
        ev = $urandom % 8;
        step(en, au, fw, eo, cv, 4'($urandom), ev == 0, ev == 1, 4'($urandom % 15 + 1),
             "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule